// File: doc/BRIEF.md
# Multiplexed-Bus Configurable I/O Port Controller

This block sits on a multiplexed 8-bit address/data bus. A pulse on `ale` captures the low byte and the memory/I/O select into an address latch. The reads and writes that follow use that latched address, whatever `ad_in` carries at the time. With memory selected, the latched byte addresses a 256-word scratch RAM. With I/O selected, the three low address bits pick one of six registers: the command register, two 8-bit ports, a 6-bit port, and the low and high bytes of a timer that sits outside this block.

The command register sets the direction of each 8-bit port and enables the two port interrupts. It also places the 6-bit port in one of four arrangements: all inputs, all outputs, handshake lines for the first port only, or handshake lines for both ports. In the handshake arrangements, a peripheral strobe latches data into an input port, raises a buffer-full flag and, on the trailing edge, raises an interrupt request. A read of the port returns the latched data and clears both flags.

Top module: `mbio_ctrl`

## Requirements
- R1: After reset, `pa_oe`, `pb_oe` and `pc_oe` are all 0, `pc_out` is 0, and a read of I/O offset 0 (status) returns 0.
- R2: A cycle with `ale`=1 latches `ad_in` and `io_sel` at the clock edge. Later cycles with `rd_en` or `wr_en` use that latched address, even when `ad_in` changes, until the next `ale`. Read data appears on `rd_data` after the clock edge of the `rd_en` cycle and holds until the next read.
- R3: With `io_sel`=0 latched, writes and reads go to a 256x8 RAM at the latched byte. A RAM access never changes an I/O register, and an I/O write never changes the RAM.
- R4: Command bit 0 sets port A direction and bit 1 sets port B direction (1 = output). An output port drives its latch on `pa_out`/`pb_out` with `pa_oe`/`pb_oe`=1, and a read returns the latch. A read of an input port that is not in handshake returns the input pins.
- R5: Command bits 3:2 = 00 make `pc_oe`=0, and a read of I/O offset 3 returns `pc_in`. Bits 3:2 = 01 make `pc_oe`=6'h3F, `pc_out` equals the port C latch, and a read returns the latch.
- R6: Command bits 3:2 = 10 give `pc_oe`=6'b111011. PC0 is port A interrupt request, PC1 is port A buffer-full, PC2 is the port A strobe input, and PC5..PC3 drive latch bits 5:3.
- R7: Command bits 3:2 = 11 give `pc_oe`=6'b011011. PC2..PC0 are as in R6, PC3 is port B interrupt request, PC4 is port B buffer-full, and PC5 is the port B strobe input.
- R8: When an input port is in handshake, a falling strobe latches the port pins and sets its buffer-full flag. A read of that port returns the latched data and clears buffer-full and interrupt request.
- R9: A rising strobe on a handshake input port sets its interrupt request only when the port's enable is 1 (bit 4 for A, bit 5 for B).
- R10: A read of I/O offset 0 returns {2'b00, enable B, buffer-full B, interrupt B, enable A, buffer-full A, interrupt A}.
- R11: A write to I/O offset 4 or 5 gives a one-cycle `tmr_wr` pulse after the edge, with `tmr_hi`=0 or 1 and `tmr_data` equal to the written byte. A command write pulses `tmr_cmd_vld` with `tmr_cmd` = bits 7:6. Reads of offsets 4 and 5 return 0.
- R12: When a port read and a strobe edge fall in the same cycle, the read returns the previously latched data, and the strobe event wins over the read's clearing of buffer-full or interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch enable |
| io_sel | input | 1 | 1 = I/O registers, 0 = RAM (latched with ale) |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| ad_in | input | 8 | Multiplexed address/data in |
| rd_data | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 6 | Port C pins in |
| pc_out | output | 6 | Port C driven values (0 where not driven) |
| pc_oe | output | 6 | Port C per-pin drive enable |
| tmr_wr | output | 1 | Timer byte write pulse |
| tmr_hi | output | 1 | Timer byte select, 1 = high |
| tmr_data | output | 8 | Timer byte value |
| tmr_cmd_vld | output | 1 | Timer command pulse |
| tmr_cmd | output | 2 | Timer command code |

## Verification
A bus read of a handshake port and a strobe edge from the peripheral can land on the same clock edge. One path clears the flags while the other sets them, and the data latch is read while it is being overwritten. The bench latches the address first. It then raises `rd_en` on port B in the same cycle that it drops and, later, raises the port B strobe with fresh pin data. It checks that the read returns the older byte, that buffer-full or the interrupt request stays set, and that a second read sees the new byte.

// File: rtl/mbio_pkg.sv
package mbio_pkg;
    localparam int PC_W = 6;
    localparam int REG_CNT = 6;
    localparam int REG_CMD = 0;
    localparam int REG_PA  = 1;
    localparam int REG_PB  = 2;
    localparam int REG_PC  = 3;
    localparam int REG_TLO = 4;
    localparam int REG_THI = 5;

    typedef enum logic [1:0] {
        PCM_IN   = 2'b00,
        PCM_OUT  = 2'b01,
        PCM_HSA  = 2'b10,
        PCM_HSAB = 2'b11
    } pc_mode_e;

    typedef struct packed {
        logic     inte_b;
        logic     inte_a;
        pc_mode_e pc_mode;
        logic     dir_b;
        logic     dir_a;
    } cmd_t;
endpackage

// File: rtl/mbio_bus_decode.sv
module mbio_bus_decode
    import mbio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              io_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] addr_o,
    output logic              is_io_o,
    output logic [REG_CNT-1:0] io_wr_o,
    output logic              rd_pa_o,
    output logic              rd_pb_o,
    output logic              ram_we_o
);
    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              io;
    } dec_t;

    dec_t q, d;

    always_comb begin
        d = q;
        if (ale) begin
            d.addr = ad_in;
            d.io   = io_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        io_wr_o = '0;
        for (int i = 0; i < REG_CNT; i++) begin
            io_wr_o[i] = wr_en && q.io && (q.addr[2:0] == 3'(i));
        end
    end

    assign addr_o   = q.addr;
    assign is_io_o  = q.io;
    assign rd_pa_o  = rd_en && q.io && (q.addr[2:0] == 3'(REG_PA));
    assign rd_pb_o  = rd_en && q.io && (q.addr[2:0] == 3'(REG_PB));
    assign ram_we_o = wr_en && !q.io;

    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(io_wr_o));
    p_ram_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (io_wr_o == '0));
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_o));
endmodule

// File: rtl/mbio_ram.sv
module mbio_ram #(
    parameter int WORDS  = 256,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/mbio_hs_port.sv
module mbio_hs_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hs_en,
    input  logic         inte,
    input  logic         stb,
    input  logic         rd_port,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] data_o,
    output logic         bf_o,
    output logic         intr_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         bf;
        logic         intr;
        logic         stb_prev;
    } hs_t;

    hs_t q, d;
    logic fall, rise;

    assign fall = hs_en && q.stb_prev && !stb;
    assign rise = hs_en && !q.stb_prev && stb;

    always_comb begin
        d = q;
        d.stb_prev = stb;
        if (!hs_en) begin
            d.bf   = 1'b0;
            d.intr = 1'b0;
        end else begin
            if (rd_port) begin
                d.bf   = 1'b0;
                d.intr = 1'b0;
            end
            if (fall) begin
                d.data = pin_in;
                d.bf   = 1'b1;
            end
            if (rise && inte) d.intr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.stb_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.data;
    assign bf_o   = q.bf;
    assign intr_o = q.intr;

    p_fall_sets_bf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> bf_o);
    p_fall_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (data_o == $past(pin_in)));
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && rd_port && !fall) |=> !bf_o);
    p_rise_intr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && inte) |=> intr_o);
    p_no_intr_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inte && !intr_o) |=> !intr_o);
endmodule

// File: rtl/mbio_ctrl.sv
module mbio_ctrl
    import mbio_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RAM_WORDS = 256,
    localparam int RAM_AW   = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              io_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [PC_W-1:0]   pc_in,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe,
    output logic              tmr_wr,
    output logic              tmr_hi,
    output logic [DATA_W-1:0] tmr_data,
    output logic              tmr_cmd_vld,
    output logic [1:0]        tmr_cmd
);
    typedef struct packed {
        cmd_t              cmd;
        logic [DATA_W-1:0] pa_lat;
        logic [DATA_W-1:0] pb_lat;
        logic [PC_W-1:0]   pc_lat;
        logic [DATA_W-1:0] rd_data;
        logic              tmr_wr;
        logic              tmr_hi;
        logic [DATA_W-1:0] tmr_data;
        logic              tmr_cmd_vld;
        logic [1:0]        tmr_cmd;
    } top_t;

    top_t q, d;

    logic [DATA_W-1:0]  addr;
    logic               is_io;
    logic [REG_CNT-1:0] io_wr;
    logic               rd_pa, rd_pb, ram_we;
    logic [DATA_W-1:0]  ram_rdata;

    mbio_bus_decode #(.DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ale(ale), .io_sel(io_sel),
        .wr_en(wr_en), .rd_en(rd_en), .ad_in(ad_in),
        .addr_o(addr), .is_io_o(is_io), .io_wr_o(io_wr),
        .rd_pa_o(rd_pa), .rd_pb_o(rd_pb), .ram_we_o(ram_we)
    );

    mbio_ram #(.WORDS(RAM_WORDS), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .we(ram_we), .addr(addr[RAM_AW-1:0]),
        .wdata(ad_in), .rdata(ram_rdata)
    );

    // Handshake lanes: index 0 = port A (strobe PC2), index 1 = port B (strobe PC5)
    logic [1:0]        hs_en, hs_inte, hs_stb, hs_rd, hs_bf, hs_intr;
    logic [DATA_W-1:0] hs_pin  [2];
    logic [DATA_W-1:0] hs_data [2];

    assign hs_en[0]   = q.cmd.pc_mode[1] && !q.cmd.dir_a;
    assign hs_en[1]   = (q.cmd.pc_mode == PCM_HSAB) && !q.cmd.dir_b;
    assign hs_inte[0] = q.cmd.inte_a;
    assign hs_inte[1] = q.cmd.inte_b;
    assign hs_stb[0]  = pc_in[2];
    assign hs_stb[1]  = pc_in[5];
    assign hs_rd[0]   = rd_pa;
    assign hs_rd[1]   = rd_pb;
    assign hs_pin[0]  = pa_in;
    assign hs_pin[1]  = pb_in;

    for (genvar g = 0; g < 2; g++) begin : g_hs
        mbio_hs_port #(.W(DATA_W)) u_hs (
            .clk(clk), .rst_n(rst_n), .hs_en(hs_en[g]), .inte(hs_inte[g]),
            .stb(hs_stb[g]), .rd_port(hs_rd[g]), .pin_in(hs_pin[g]),
            .data_o(hs_data[g]), .bf_o(hs_bf[g]), .intr_o(hs_intr[g])
        );
    end

    logic [DATA_W-1:0] rd_mux, pa_rd, pb_rd;
    logic [PC_W-1:0]   pc_rd;
    logic [7:0]        status;

    assign status = {2'b00, q.cmd.inte_b, hs_bf[1], hs_intr[1],
                     q.cmd.inte_a, hs_bf[0], hs_intr[0]};
    assign pa_rd = q.cmd.dir_a ? q.pa_lat : (hs_en[0] ? hs_data[0] : pa_in);
    assign pb_rd = q.cmd.dir_b ? q.pb_lat : (hs_en[1] ? hs_data[1] : pb_in);

    always_comb begin
        case (q.cmd.pc_mode)
            PCM_IN:  pc_rd = pc_in;
            PCM_OUT: pc_rd = q.pc_lat;
            PCM_HSA: pc_rd = {q.pc_lat[5:3], pc_in[2], hs_bf[0], hs_intr[0]};
            default: pc_rd = {pc_in[5], hs_bf[1], hs_intr[1],
                              pc_in[2], hs_bf[0], hs_intr[0]};
        endcase
    end

    always_comb begin
        rd_mux = '0;
        if (!is_io) begin
            rd_mux = ram_rdata;
        end else begin
            case (int'(addr[2:0]))
                REG_CMD: rd_mux = DATA_W'(status);
                REG_PA:  rd_mux = pa_rd;
                REG_PB:  rd_mux = pb_rd;
                REG_PC:  rd_mux = DATA_W'(pc_rd);
                default: rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        d = q;
        d.tmr_wr      = 1'b0;
        d.tmr_cmd_vld = 1'b0;
        if (io_wr[REG_CMD]) begin
            d.cmd         = cmd_t'(ad_in[5:0]);
            d.tmr_cmd_vld = 1'b1;
            d.tmr_cmd     = ad_in[7:6];
        end
        if (io_wr[REG_PA]) d.pa_lat = ad_in;
        if (io_wr[REG_PB]) d.pb_lat = ad_in;
        if (io_wr[REG_PC]) d.pc_lat = ad_in[PC_W-1:0];
        if (io_wr[REG_TLO] || io_wr[REG_THI]) begin
            d.tmr_wr   = 1'b1;
            d.tmr_hi   = io_wr[REG_THI];
            d.tmr_data = ad_in;
        end
        if (rd_en) d.rd_data = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.cmd.pc_mode)
            PCM_IN: begin
                pc_oe  = 6'b000000;
                pc_out = 6'b000000;
            end
            PCM_OUT: begin
                pc_oe  = 6'b111111;
                pc_out = q.pc_lat;
            end
            PCM_HSA: begin
                pc_oe  = 6'b111011;
                pc_out = {q.pc_lat[5:3], 1'b0, hs_bf[0], hs_intr[0]};
            end
            default: begin
                pc_oe  = 6'b011011;
                pc_out = {1'b0, hs_bf[1], hs_intr[1], 1'b0, hs_bf[0], hs_intr[0]};
            end
        endcase
    end

    assign rd_data     = q.rd_data;
    assign pa_out      = q.pa_lat;
    assign pa_oe       = q.cmd.dir_a;
    assign pb_out      = q.pb_lat;
    assign pb_oe       = q.cmd.dir_b;
    assign tmr_wr      = q.tmr_wr;
    assign tmr_hi      = q.tmr_hi;
    assign tmr_data    = q.tmr_data;
    assign tmr_cmd_vld = q.tmr_cmd_vld;
    assign tmr_cmd     = q.tmr_cmd;

    p_dir_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr[REG_CMD] |=> (pa_oe == $past(ad_in[0])));
    p_dir_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr[REG_CMD] |=> (pb_oe == $past(ad_in[1])));
    p_pc_in_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr[REG_CMD] && ad_in[3:2] == 2'b00) |=> (pc_oe == '0));
    p_strobe_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_oe[2] == 1'b1) |-> (q.cmd.pc_mode[1] == 1'b0));
    p_tmr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (!tmr_wr || $past(io_wr[REG_TLO] || io_wr[REG_THI])));
    p_tmr_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr[REG_TLO] |=> (tmr_wr && !tmr_hi));
endmodule

// File: tb/sim_mbio_ctrl.sv
`timescale 1ns/1ps
module sim_mbio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, ale, io_sel, wr_en, rd_en;
    logic [7:0] ad_in, rd_data, pa_in, pa_out, pb_in, pb_out, tmr_data;
    logic       pa_oe, pb_oe, tmr_wr, tmr_hi, tmr_cmd_vld;
    logic [5:0] pc_in, pc_out, pc_oe;
    logic [1:0] tmr_cmd;

    always #4 clk = ~clk;

    mbio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ale(ale), .io_sel(io_sel), .wr_en(wr_en),
        .rd_en(rd_en), .ad_in(ad_in), .rd_data(rd_data),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .tmr_wr(tmr_wr), .tmr_hi(tmr_hi), .tmr_data(tmr_data),
        .tmr_cmd_vld(tmr_cmd_vld), .tmr_cmd(tmr_cmd)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mem_m [256];
    logic [7:0] addr_log [40];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_pc_oe(input logic [1:0] m);
        case (m)
            2'b00:   return 6'b000000;
            2'b01:   return 6'b111111;
            2'b10:   return 6'b111011;
            default: return 6'b011011;
        endcase
    endfunction

    function automatic logic [5:0] exp_pc_out_idle(input logic [1:0] m, input logic [5:0] lat);
        case (m)
            2'b00:   return 6'b000000;
            2'b01:   return lat;
            2'b10:   return {lat[5:3], 3'b000};
            default: return 6'b000000;
        endcase
    endfunction

    task automatic set_addr(input logic io, input logic [7:0] a);
        @(negedge clk);
        ale = 1'b1; io_sel = io; ad_in = a;
        @(negedge clk);
        ale = 1'b0;
    endtask

    task automatic bus_wr(input logic io, input logic [7:0] a, input logic [7:0] v);
        set_addr(io, a);
        ad_in = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic io, input logic [7:0] a, output logic [7:0] v);
        set_addr(io, a);
        ad_in = 8'hEE; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v, v2, c, la, lb;
        logic [5:0] lc;
        logic [1:0] m;
        void'($urandom(32'd1234));
        rst_n = 1'b0; ale = 1'b0; io_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        ad_in = 8'h00; pa_in = 8'h00; pb_in = 8'h00; pc_in = 6'b100100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pa_oe", 32'(pa_oe), 0);
        chk("R1 pb_oe", 32'(pb_oe), 0);
        chk("R1 pc_oe", 32'(pc_oe), 0);
        chk("R1 pc_out", 32'(pc_out), 0);
        bus_rd(1'b1, 8'h00, v);
        chk("R1 status", 32'(v), 0);

        // R3 RAM random fill and readback
        for (int i = 0; i < 40; i++) begin
            addr_log[i] = 8'($urandom);
            v = 8'($urandom);
            mem_m[addr_log[i]] = v;
            bus_wr(1'b0, addr_log[i], v);
        end
        for (int i = 0; i < 40; i++) begin
            bus_rd(1'b0, addr_log[i], v);
            chk("R3 ram readback", 32'(v), 32'(mem_m[addr_log[i]]));
        end

        // R2 latched address holds while ad_in changes
        bus_wr(1'b0, 8'h33, 8'hA5);
        set_addr(1'b0, 8'h33);
        ad_in = 8'h01; rd_en = 1'b1;
        @(negedge clk);
        ad_in = 8'h02;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 latched addr read", 32'(rd_data), 32'hA5);
        ad_in = 8'h55;
        @(negedge clk);
        chk("R2 rd_data holds", 32'(rd_data), 32'hA5);

        // R3 isolation between RAM and I/O
        bus_wr(1'b0, 8'h01, 8'hC3);
        bus_wr(1'b1, 8'h01, 8'h11);
        bus_rd(1'b0, 8'h01, v);
        chk("R3 ram untouched by io", 32'(v), 32'hC3);
        chk("R3 port latch", 32'(pa_out), 32'h11);

        // R4 R5 R6 R7 random command / port patterns
        for (int i = 0; i < 30; i++) begin
            c = 8'($urandom) & 8'h0F;
            m = c[3:2];
            bus_wr(1'b1, 8'h00, c);
            chk("R4 pa_oe", 32'(pa_oe), 32'(c[0]));
            chk("R4 pb_oe", 32'(pb_oe), 32'(c[1]));
            chk("R5/R6/R7 pc_oe", 32'(pc_oe), 32'(exp_pc_oe(m)));
            la = 8'($urandom); lb = 8'($urandom); lc = 6'($urandom);
            pa_in = 8'($urandom); pb_in = 8'($urandom);
            bus_wr(1'b1, 8'h01, la);
            bus_wr(1'b1, 8'h02, lb);
            bus_wr(1'b1, 8'h03, {2'b00, lc});
            chk("R4 pa_out", 32'(pa_out), 32'(la));
            bus_rd(1'b1, 8'h01, v);
            chk("R4 pa read", 32'(v), c[0] ? 32'(la) : (m[1] ? 32'h0 : 32'(pa_in)));
            bus_rd(1'b1, 8'h02, v);
            chk("R4 pb read", 32'(v), c[1] ? 32'(lb) : (m == 2'b11 ? 32'h0 : 32'(pb_in)));
            chk("R5/R6 pc_out", 32'(pc_out), 32'(exp_pc_out_idle(m, lc)));
            if (!m[1]) begin
                bus_rd(1'b1, 8'h03, v);
                chk("R5 pc read", 32'(v), m[0] ? 32'(lc) : 32'(pc_in));
            end
        end

        // R11 timer pass-through
        bus_wr(1'b1, 8'h04, 8'h34);
        chk("R11 tmr_wr lo", 32'(tmr_wr), 1);
        chk("R11 tmr_hi lo", 32'(tmr_hi), 0);
        chk("R11 tmr_data lo", 32'(tmr_data), 32'h34);
        @(negedge clk);
        chk("R11 tmr_wr one cycle", 32'(tmr_wr), 0);
        bus_wr(1'b1, 8'h05, 8'h12);
        chk("R11 tmr_hi hi", 32'(tmr_hi), 1);
        chk("R11 tmr_data hi", 32'(tmr_data), 32'h12);
        bus_wr(1'b1, 8'h00, 8'hC0);
        chk("R11 cmd pulse", 32'(tmr_cmd_vld), 1);
        chk("R11 cmd code", 32'(tmr_cmd), 3);
        bus_rd(1'b1, 8'h04, v);
        chk("R11 timer lo reads 0", 32'(v), 0);
        bus_rd(1'b1, 8'h05, v);
        chk("R11 timer hi reads 0", 32'(v), 0);

        // R6 R8 R9 R10 handshake on port A, enable set
        bus_wr(1'b1, 8'h00, 8'h18);
        pa_in = 8'h5A;
        @(negedge clk); pc_in[2] = 1'b0;
        @(negedge clk);
        chk("R8 bf_a set on PC1", 32'(pc_out[1]), 1);
        chk("R9 no intr before rise", 32'(pc_out[0]), 0);
        pa_in = 8'h77; pc_in[2] = 1'b1;
        @(negedge clk);
        chk("R9 intr_a on PC0", 32'(pc_out[0]), 1);
        bus_rd(1'b1, 8'h00, v);
        chk("R10 status full", 32'(v), 32'h07);
        bus_rd(1'b1, 8'h01, v);
        chk("R8 latched data", 32'(v), 32'h5A);
        chk("R8 flags cleared", 32'(pc_out[1:0]), 0);
        bus_rd(1'b1, 8'h00, v);
        chk("R10 status after read", 32'(v), 32'h04);

        // R9 enable clear: no interrupt
        bus_wr(1'b1, 8'h00, 8'h08);
        @(negedge clk); pc_in[2] = 1'b0;
        @(negedge clk); pc_in[2] = 1'b1;
        @(negedge clk);
        chk("R9 bf without enable", 32'(pc_out[1]), 1);
        chk("R9 masked intr", 32'(pc_out[0]), 0);
        bus_rd(1'b1, 8'h01, v);
        chk("R8 second latch", 32'(v), 32'h77);

        // R7 R12 both-port handshake, read racing the strobe on port B
        bus_wr(1'b1, 8'h00, 8'h2C);
        chk("R7 pc_oe", 32'(pc_oe), 32'h1B);
        pb_in = 8'h3C;
        @(negedge clk); pc_in[5] = 1'b0;
        @(negedge clk); pc_in[5] = 1'b1;
        @(negedge clk);
        chk("R7 bf_b on PC4", 32'(pc_out[4]), 1);
        chk("R7 intr_b on PC3", 32'(pc_out[3]), 1);
        set_addr(1'b1, 8'h02);
        pb_in = 8'h99; rd_en = 1'b1; pc_in[5] = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R12 read returns old data", 32'(rd_data), 32'h3C);
        chk("R12 bf set wins", 32'(pc_out[4]), 1);
        chk("R12 intr cleared by read", 32'(pc_out[3]), 0);
        rd_en = 1'b1; pc_in[5] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v2 = rd_data;
        chk("R12 new data", 32'(v2), 32'h99);
        chk("R12 intr set wins", 32'(pc_out[3]), 1);
        chk("R12 bf cleared", 32'(pc_out[4]), 0);

        finish_run();
    end
endmodule